// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block holds the software-visible control and status word of every channel in a bank of DMA channels. It also gathers the channels' interrupt causes into one shared interrupt line. Each channel word puts three things side by side: read/write control bits, sticky interrupt flags that are cleared by writing a one, and read-only state bits. Software reads a channel word and writes the same value back. That write clears exactly the flags it saw, and the control bits keep their values.

The channel engines pulse four kinds of events into the block: transfer start, descriptor end (together with that descriptor's end-interrupt enable), bus error and engine stop. Each channel runs a two-state machine. `CH_STOPPED` is the reset state. The `GO` transition leaves it on a write with the run bit set, unless a stop pulse arrives in the same cycle. `CH_RUNNING` takes the `HALT` transition back to `CH_STOPPED` on a stop pulse. A summary word holds one pending bit per channel. The shared interrupt is the OR of those bits, so a handler can read the summary once and service only the channels whose bits are set. An alignment word holds one bit per channel. A set bit permits byte-aligned addresses on that channel, and the bit is driven straight out to the engine.

Top module: `dmastat_agg`

## Requirements
- R1: Channel n (n < NUM_CH) has its word at byte offset 4*n, and the two low address bits are ignored. Bit 31 (run), bit 30 (no-descriptor-fetch) and bit 29 (stop-interrupt enable) read back as last written. All three are 0 after reset.
- R2: `run_o[n]` and `nodesc_o[n]` follow bits 31 and 30 of channel n's word. They change only in the cycle after a write to that word.
- R3: Bit 3 reads 1 in `CH_STOPPED`, which is the reset state. `GO` (a write with bit 31 = 1) gives 0 from the next cycle. `HALT` (a pulse on `ev_stop[n]`) gives 1 from the next cycle. A stop pulse in the same cycle as a `GO` write wins.
- R4: Bit 8 reads the current `req_pend[n]` input. Writes to bits 8 and 3 have no effect.
- R5: The flags are bit 2 (end), bit 1 (start) and bit 0 (bus error). Each is set by its event and stays set until a write to the channel word has a 1 in that bit position. A 0 in that position leaves the flag alone. Writing back a value just read clears the flags seen and leaves the control bits unchanged.
- R6: An event arriving in the same cycle as a write that clears its flag leaves the flag set.
- R7: The end flag is set only by `ev_end[n]` with `ev_end_ien[n]` high in the same cycle.
- R8: Channel n is pending while any of its flags is set, or while it is stopped with stop-interrupt enable set. The summary word at offset 0x0F0 shows channel n's pending state in bit n. Writes to the summary word are ignored.
- R9: `irq_o` is high exactly while some summary bit is set. It falls in the cycle after the write that clears the last pending cause.
- R10: The alignment word at offset 0x0A0 is readable and writable. Bit n drives `align_o[n]`. Its reset value is 0.
- R11: Addresses that map to nothing read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address of the word read or written |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| ev_start | input | NUM_CH | Transfer-start pulse per channel |
| ev_end | input | NUM_CH | Descriptor-end pulse per channel |
| ev_end_ien | input | NUM_CH | End-interrupt enable of the completing descriptor |
| ev_buserr | input | NUM_CH | Bus-error pulse per channel |
| ev_stop | input | NUM_CH | Engine-stopped pulse per channel |
| req_pend | input | NUM_CH | Peripheral request pending, per channel |
| run_o | output | NUM_CH | Run control per channel |
| nodesc_o | output | NUM_CH | No-descriptor-fetch mode per channel |
| align_o | output | NUM_CH | Byte-alignment permission per channel |
| irq_o | output | 1 | Shared interrupt |

## Verification
The hardest case to reach is an event that lands in the same clock as the write-back that clears its flag. Software reaching it by chance would depend on the engine and the bus lining up, so the stimulus drives the event pulse and the clearing write in one cycle on purpose. It does this both for a flag that was already set and for the `GO`-versus-`HALT` race on the state bit. A long random phase then mixes events on many channels with writes to random words, including write-backs with control bits set. The behavioural model is compared against every read, every output and the interrupt line on every cycle.

// File: rtl/dmastat_pkg.sv
`timescale 1ns/1ps
package dmastat_pkg;
    localparam int CSR_W = 32;

    // bit positions inside a channel word (software decodes these)
    localparam int B_RUN     = 31;
    localparam int B_NODESC  = 30;
    localparam int B_STOPIE  = 29;
    localparam int B_REQ     = 8;
    localparam int B_STOPPED = 3;
    localparam int B_END     = 2;
    localparam int B_START   = 1;
    localparam int B_BERR    = 0;

    localparam int ALIGN_OFS   = 'h0A0;
    localparam int SUMMARY_OFS = 'h0F0;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    // write-data bits a channel word cares about
    typedef struct packed {
        logic run;
        logic nodesc;
        logic stopie;
        logic clr_end;
        logic clr_start;
        logic clr_berr;
    } ch_wr_t;

    // status bits a channel reports
    typedef struct packed {
        logic stopped;
        logic f_end;
        logic f_start;
        logic f_berr;
    } ch_stat_t;
endpackage

// File: rtl/dmastat_chan.sv
`timescale 1ns/1ps
module dmastat_chan
    import dmastat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     csr_wr,
    input  ch_wr_t   wr,
    input  logic     ev_start,
    input  logic     ev_end,
    input  logic     ev_end_ien,
    input  logic     ev_buserr,
    input  logic     ev_stop,
    output logic     run,
    output logic     nodesc,
    output logic     stopie,
    output ch_stat_t stat,
    output logic     pend
);
    ch_state_e st_q, st_d;
    logic run_q, nodesc_q, stopie_q;
    logic f_end_q, f_start_q, f_berr_q;

    // transitions: GO on a run write, HALT on a stop pulse (stop wins)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_STOPPED: if (csr_wr && wr.run && !ev_stop) st_d = CH_RUNNING;
            CH_RUNNING: if (ev_stop) st_d = CH_STOPPED;
            default:    st_d = CH_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= CH_STOPPED;
            run_q     <= 1'b0;
            nodesc_q  <= 1'b0;
            stopie_q  <= 1'b0;
            f_end_q   <= 1'b0;
            f_start_q <= 1'b0;
            f_berr_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (csr_wr) begin
                run_q    <= wr.run;
                nodesc_q <= wr.nodesc;
                stopie_q <= wr.stopie;
            end
            // a new event beats a same-cycle clear
            f_end_q   <= (f_end_q   && !(csr_wr && wr.clr_end))   || (ev_end && ev_end_ien);
            f_start_q <= (f_start_q && !(csr_wr && wr.clr_start)) || ev_start;
            f_berr_q  <= (f_berr_q  && !(csr_wr && wr.clr_berr))  || ev_buserr;
        end
    end

    always_comb begin
        run          = run_q;
        nodesc       = nodesc_q;
        stopie       = stopie_q;
        stat.stopped = (st_q == CH_STOPPED);
        stat.f_end   = f_end_q;
        stat.f_start = f_start_q;
        stat.f_berr  = f_berr_q;
        pend = f_end_q || f_start_q || f_berr_q || (stopie_q && (st_q == CH_STOPPED));
    end
endmodule

// File: rtl/dmastat_regdec.sv
`timescale 1ns/1ps
module dmastat_regdec
    import dmastat_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr,
    input  logic [NUM_CH-1:0]             run,
    input  logic [NUM_CH-1:0]             nodesc,
    input  logic [NUM_CH-1:0]             stopie,
    input  logic [NUM_CH-1:0]             req,
    input  ch_stat_t [NUM_CH-1:0]         stat,
    input  logic [NUM_CH-1:0]             align,
    input  logic [NUM_CH-1:0]             pend,
    output logic [NUM_CH-1:0]             csr_sel,
    output logic                          align_wr,
    output logic [CSR_W-1:0]              rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             csr_hit;
    logic             align_hit;
    logic             sum_hit;

    assign widx      = addr[ADDR_W-1:2];
    assign csr_hit   = (widx < IDX_W'(NUM_CH));
    assign align_hit = (addr == ADDR_W'(ALIGN_OFS));
    assign sum_hit   = (addr == ADDR_W'(SUMMARY_OFS));
    assign align_wr  = wr && align_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign csr_sel[g] = wr && csr_hit && (widx == IDX_W'(g));
    end

    always_comb begin
        rdata = '0;
        if (csr_hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (widx == IDX_W'(c)) begin
                    rdata[B_RUN]     = run[c];
                    rdata[B_NODESC]  = nodesc[c];
                    rdata[B_STOPIE]  = stopie[c];
                    rdata[B_REQ]     = req[c];
                    rdata[B_STOPPED] = stat[c].stopped;
                    rdata[B_END]     = stat[c].f_end;
                    rdata[B_START]   = stat[c].f_start;
                    rdata[B_BERR]    = stat[c].f_berr;
                end
            end
        end else if (align_hit) begin
            rdata = CSR_W'(align);
        end else if (sum_hit) begin
            rdata = CSR_W'(pend);
        end
    end
endmodule

// File: rtl/dmastat_agg.sv
`timescale 1ns/1ps
module dmastat_agg
    import dmastat_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_end_ien,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_stop,
    input  logic [NUM_CH-1:0] req_pend,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] nodesc_o,
    output logic [NUM_CH-1:0] align_o,
    output logic              irq_o
);
    ch_wr_t                ch_wr;
    logic [NUM_CH-1:0]     csr_sel;
    logic                  align_wr;
    logic [NUM_CH-1:0]     stopie;
    logic [NUM_CH-1:0]     pend;
    ch_stat_t [NUM_CH-1:0] stat;
    logic [NUM_CH-1:0]     align_q;

    assign ch_wr.run       = bus_wdata[B_RUN];
    assign ch_wr.nodesc    = bus_wdata[B_NODESC];
    assign ch_wr.stopie    = bus_wdata[B_STOPIE];
    assign ch_wr.clr_end   = bus_wdata[B_END];
    assign ch_wr.clr_start = bus_wdata[B_START];
    assign ch_wr.clr_berr  = bus_wdata[B_BERR];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmastat_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .csr_wr     (csr_sel[g]),
            .wr         (ch_wr),
            .ev_start   (ev_start[g]),
            .ev_end     (ev_end[g]),
            .ev_end_ien (ev_end_ien[g]),
            .ev_buserr  (ev_buserr[g]),
            .ev_stop    (ev_stop[g]),
            .run        (run_o[g]),
            .nodesc     (nodesc_o[g]),
            .stopie     (stopie[g]),
            .stat       (stat[g]),
            .pend       (pend[g])
        );
    end

    dmastat_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regdec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .run      (run_o),
        .nodesc   (nodesc_o),
        .stopie   (stopie),
        .req      (req_pend),
        .stat     (stat),
        .align    (align_q),
        .pend     (pend),
        .csr_sel  (csr_sel),
        .align_wr (align_wr),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        align_q <= '0;
        else if (align_wr) align_q <= bus_wdata[NUM_CH-1:0];
    end

    assign align_o = align_q;
    assign irq_o   = |pend;
endmodule

// File: rtl/dmastat_agg_chk.sv
`timescale 1ns/1ps
module dmastat_agg_chk
    import dmastat_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  wr_run,
    input logic                  wr_nodesc,
    input logic                  wr_clr_end,
    input logic                  wr_clr_start,
    input logic                  wr_clr_berr,
    input logic [NUM_CH-1:0]     csr_sel,
    input ch_stat_t [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0]     ev_start,
    input logic [NUM_CH-1:0]     ev_end,
    input logic [NUM_CH-1:0]     ev_end_ien,
    input logic [NUM_CH-1:0]     ev_buserr,
    input logic [NUM_CH-1:0]     ev_stop,
    input logic [NUM_CH-1:0]     run_o,
    input logic [NUM_CH-1:0]     nodesc_o,
    input logic                  irq_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
        a_r2_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !csr_sel[g] |=> $stable(run_o[g]));
        a_r2_nodesc_load: assert property (@(posedge clk) disable iff (!rst_n)
            csr_sel[g] |=> (nodesc_o[g] == $past(wr_nodesc)));
        a_r3_go: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_sel[g] && wr_run && !ev_stop[g]) |=> !stat[g].stopped);
        a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
            ev_stop[g] |=> stat[g].stopped);
        a_r5_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g].f_end && !(csr_sel[g] && wr_clr_end)) |=> stat[g].f_end);
        a_r5_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g].f_start && !(csr_sel[g] && wr_clr_start)) |=> stat[g].f_start);
        a_r5_berr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g].f_berr && !(csr_sel[g] && wr_clr_berr)) |=> stat[g].f_berr);
        a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_buserr[g] || ev_start[g]) |=> (stat[g].f_berr || stat[g].f_start));
        a_r7_end_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat[g].f_end && !(ev_end[g] && ev_end_ien[g])) |=> !stat[g].f_end);
    end

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !bus_wr && (ev_start == '0) && ((ev_end & ev_end_ien) == '0)
         && (ev_buserr == '0) && (ev_stop == '0)) |=> !irq_o);
endmodule

bind dmastat_agg dmastat_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .wr_run       (ch_wr.run),
    .wr_nodesc    (ch_wr.nodesc),
    .wr_clr_end   (ch_wr.clr_end),
    .wr_clr_start (ch_wr.clr_start),
    .wr_clr_berr  (ch_wr.clr_berr),
    .csr_sel      (csr_sel),
    .stat         (stat),
    .ev_start     (ev_start),
    .ev_end       (ev_end),
    .ev_end_ien   (ev_end_ien),
    .ev_buserr    (ev_buserr),
    .ev_stop      (ev_stop),
    .run_o        (run_o),
    .nodesc_o     (nodesc_o),
    .irq_o        (irq_o)
);

// File: tb/test_dmastat_agg.sv
`timescale 1ns/1ps
module test_dmastat_agg;
    localparam int NCH = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  ev_start = '0, ev_end = '0, ev_ien = '0, ev_berr = '0, ev_stop = '0, req = '0;
    logic [NCH-1:0]  run_o, nodesc_o, align_o;
    logic            irq_o;

    int    checks = 0;
    int    errors = 0;
    string cur = "R1";

    // reference model state
    bit m_run[NCH], m_nd[NCH], m_sie[NCH], m_stp[NCH], m_fe[NCH], m_fs[NCH], m_fb[NCH];
    bit [31:0] m_align;

    always #10 clk = ~clk;

    dmastat_agg i_dmastat_agg (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .ev_start(ev_start), .ev_end(ev_end), .ev_end_ien(ev_ien),
        .ev_buserr(ev_berr), .ev_stop(ev_stop), .req_pend(req), .run_o(run_o),
        .nodesc_o(nodesc_o), .align_o(align_o), .irq_o(irq_o)
    );

    function automatic bit m_pend(int c);
        return m_fe[c] | m_fs[c] | m_fb[c] | (m_stp[c] & m_sie[c]);
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        int idx = int'(a >> 2);
        logic [31:0] v = '0;
        if (idx < NCH) begin
            v[31] = m_run[idx]; v[30] = m_nd[idx]; v[29] = m_sie[idx];
            v[8] = req[idx]; v[3] = m_stp[idx];
            v[2] = m_fe[idx]; v[1] = m_fs[idx]; v[0] = m_fb[idx];
        end else if (a == 12'h0A0) begin
            v = m_align;
        end else if (a == 12'h0F0) begin
            for (int c = 0; c < NCH; c++) v[c] = m_pend(c);
        end
        return v;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_run[c] = 0; m_nd[c] = 0; m_sie[c] = 0; m_stp[c] = 1;
            m_fe[c] = 0; m_fs[c] = 0; m_fb[c] = 0;
        end
        m_align = '0;
    endtask

    task automatic compare();
        logic [31:0] e_run = '0, e_nd = '0, e_rd;
        bit e_irq = 0;
        for (int c = 0; c < NCH; c++) begin
            e_run[c] = m_run[c]; e_nd[c] = m_nd[c];
            e_irq = e_irq | m_pend(c);
        end
        e_rd = exp_rd(addr);
        chk(rdata === e_rd, cur, "rdata", rdata, e_rd);
        chk(irq_o === e_irq, "R9", "irq_o", 32'(irq_o), 32'(e_irq));
        chk(run_o === e_run, "R2", "run_o", run_o, e_run);
        chk(nodesc_o === e_nd, "R2", "nodesc_o", nodesc_o, e_nd);
        chk(align_o === m_align, "R10", "align_o", align_o, m_align);
    endtask

    // one clock: model takes the inputs at the edge, outputs compared mid-cycle
    task automatic tick();
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            bit hit = wr && (int'(addr >> 2) == c);
            m_fe[c] = (m_fe[c] & !(hit && wdata[2])) | (ev_end[c] & ev_ien[c]);
            m_fs[c] = (m_fs[c] & !(hit && wdata[1])) | ev_start[c];
            m_fb[c] = (m_fb[c] & !(hit && wdata[0])) | ev_berr[c];
            if (ev_stop[c]) m_stp[c] = 1;
            else if (hit && wdata[31]) m_stp[c] = 0;
            if (hit) begin
                m_run[c] = wdata[31]; m_nd[c] = wdata[30]; m_sie[c] = wdata[29];
            end
        end
        if (wr && addr == 12'h0A0) m_align = wdata;
        @(negedge clk);
        compare();
        wr = 0; ev_start = '0; ev_end = '0; ev_ien = '0; ev_berr = '0; ev_stop = '0;
    endtask

    task automatic wr_word(logic [11:0] a, logic [31:0] d);
        wr = 1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd_word(logic [11:0] a);
        addr = a;
        tick();
    endtask

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state: stopped, nothing pending
        cur = "R3"; rd_word(12'h000);
        chk(rdata === 32'h0000_0008, "R3", "reset word", rdata, 32'h8);

        // R1/R2: control bits, channel at 4n, low address bits ignored
        cur = "R1";
        wr_word(12'h000, 32'hE000_0000);
        rd_word(12'h000);
        chk(rdata === 32'hE000_0000, "R1", "ch0 ctrl", rdata, 32'hE000_0000);
        wr_word(12'h07F, 32'h4000_0000);
        rd_word(12'h07C);
        chk(rdata === 32'h4000_0008, "R1", "ch31 word", rdata, 32'h4000_0008);

        // R4: request pending reads through, read-only bits unwritable
        cur = "R4";
        req[5] = 1; rd_word(12'h014);
        chk(rdata === 32'h0000_0108, "R4", "req bit", rdata, 32'h108);
        wr_word(12'h014, 32'h0000_0100);
        rd_word(12'h014);
        chk(rdata === 32'h0000_0108, "R4", "ro bits", rdata, 32'h108);
        req[5] = 0;

        // R5: sticky flags, write-zero ignored, write-back clears
        cur = "R5";
        ev_start[2] = 1; ev_berr[2] = 1; ev_end[2] = 1; ev_ien[2] = 1; addr = 12'h008; tick();
        chk(rdata === 32'h0000_000F, "R5", "flags set", rdata, 32'hF);
        wr_word(12'h008, 32'h0);
        rd_word(12'h008);
        chk(rdata === 32'h0000_000F, "R5", "zero write", rdata, 32'hF);
        wr_word(12'h008, 32'h0000_000F);
        chk(irq_o === 1'b0, "R9", "irq drop", 32'(irq_o), 32'h0);
        ev_end[0] = 1; ev_ien[0] = 1; rd_word(12'h000);
        chk(rdata === 32'hE000_0004, "R5", "ch0 end", rdata, 32'hE000_0004);
        wr_word(12'h000, 32'hE000_0004);
        rd_word(12'h000);
        chk(rdata === 32'hE000_0000, "R5", "write-back", rdata, 32'hE000_0000);

        // R6: event in the same cycle as the clearing write
        cur = "R6";
        ev_end[3] = 1; ev_ien[3] = 1; rd_word(12'h00C);
        ev_end[3] = 1; ev_ien[3] = 1; wr_word(12'h00C, 32'h0000_0004);
        rd_word(12'h00C);
        chk(rdata === 32'h0000_000C, "R6", "kept", rdata, 32'hC);
        ev_stop[6] = 1; wr_word(12'h018, 32'h8000_0000);
        rd_word(12'h018);
        chk(rdata === 32'h8000_0008, "R3", "stop beats go", rdata, 32'h8000_0008);
        wr_word(12'h00C, 32'h0000_0004);

        // R7: end without the descriptor enable
        cur = "R7";
        ev_end[4] = 1; ev_ien[4] = 0; rd_word(12'h010);
        chk(rdata === 32'h0000_0008, "R7", "unqualified end", rdata, 32'h8);

        // R8/R3: HALT raises stop interrupt when enabled, summary read-only
        cur = "R8";
        ev_stop[0] = 1; rd_word(12'h0F0);
        chk(rdata === 32'h0000_0001, "R8", "summary", rdata, 32'h1);
        wr_word(12'h0F0, 32'hFFFF_FFFF);
        rd_word(12'h0F0);
        chk(rdata === 32'h0000_0001, "R8", "summary ro", rdata, 32'h1);
        wr_word(12'h000, 32'h8000_0000);
        chk(irq_o === 1'b0, "R9", "irq after go", 32'(irq_o), 32'h0);

        // R10: alignment word
        cur = "R10";
        wr_word(12'h0A0, 32'hA5A5_A5A5);
        rd_word(12'h0A0);
        chk(align_o === 32'hA5A5_A5A5, "R10", "align_o", align_o, 32'hA5A5_A5A5);

        // R11: unmapped word
        cur = "R11";
        wr_word(12'h0C0, 32'hFFFF_FFFF);
        rd_word(12'h0C0);
        chk(rdata === 32'h0, "R11", "unmapped", rdata, 32'h0);

        // mixed random traffic
        cur = "R8";
        for (int i = 0; i < 400; i++) begin
            ev_start = $urandom & $urandom & $urandom;
            ev_end   = $urandom & $urandom & $urandom;
            ev_ien   = $urandom;
            ev_berr  = $urandom & $urandom & $urandom & $urandom;
            ev_stop  = $urandom & $urandom & $urandom;
            req      = $urandom;
            wr       = ($urandom % 3) == 0;
            case ($urandom % 4)
                0:       addr = 12'h0A0;
                1:       addr = 12'h0F0;
                default: addr = 12'(($urandom % NCH) * 4);
            endcase
            wdata = $urandom;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule